// File: doc/BRIEF.md
# Self-Correcting Decade Ring Counter

This block counts through ten states held in a five-stage twisted-ring register. It decodes the state into ten one-hot outputs and gives an active-low carry for cascading. Two count inputs are sampled by the system clock, one active high and one active low. The count advances on a qualifying edge of either input, and the level of the other input gates that edge. An asynchronous active-high master reset forces state 0 at once.

A correction term in the next-state logic of one stage stops illegal five-bit patterns from circulating. Any pattern therefore rejoins the legal ten-state sequence within a bounded number of advances. A synchronous load port lets a test preload any of the 32 register patterns. The carry is high in states 0 to 4 and low in states 5 to 9. It rises at the wrap from 9 to 0, which is the edge that advances a following counter.

Top module: `jdc_counter`

## Requirements
- R1: While `rst` is high, `dec_o` is 10'b0000000001 (state 0) and `carry_n_o` is 1, taking effect without waiting for a clock edge.
- R2: A low-to-high change of `cnt_up_i` while `cnt_dn_n_i` is low advances the count by one. The new state appears on the outputs after the third rising clock edge following the input change.
- R3: A high-to-low change of `cnt_dn_n_i` while `cnt_up_i` is high advances the count by one, with the same three-edge latency.
- R4: No other change of the count inputs advances the count. This covers a rising `cnt_up_i` while `cnt_dn_n_i` is high, a falling `cnt_dn_n_i` while `cnt_up_i` is low, a falling `cnt_up_i` and a rising `cnt_dn_n_i`.
- R5: When both qualifying edges arrive in the same clock cycle, the count advances by exactly one.
- R6: In a legal state k (0..9), exactly `dec_o[k]` is high. Advances step k to (k+1) mod 10.
- R7: `carry_n_o` is 0 in states 5 to 9 and 1 in states 0 to 4, so it rises at the 9-to-0 wrap.
- R8: From any of the 32 register patterns, at most 11 advances lead to a legal state. The following advances then follow the sequence of R6.
- R9: With `ld_en_i` high at a rising clock edge, the register takes `ld_pat_i`, and loading takes precedence over advancing. Bit 0 is the first stage. State k holds ones in bits [k-1:0] for k in 0..5. For k in 6..9 it holds zeros in bits [k-6:0] and ones above them.
- R10: Master reset overrides both loading and counting for as long as it is high.
- R11: Count-input levels held across the release of reset do not produce an advance after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst | input | 1 | Asynchronous active-high master reset |
| cnt_up_i | input | 1 | Active-high count input, advances on its rising edge |
| cnt_dn_n_i | input | 1 | Active-low count input, advances on its falling edge |
| ld_en_i | input | 1 | Test load enable |
| ld_pat_i | input | 5 | Pattern loaded into the ring register |
| dec_o | output | 10 | One-hot decoded state |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
A count-input change made just after a falling clock edge passes two synchronizer flops and one history flop. The ring register therefore updates on the third rising edge, and the decode is combinational from it. The bench samples one falling edge before that update to confirm the old state and one falling edge after it to confirm the new state. A load is due at the first rising edge, so its result is checked at the next falling edge. Reset is checked between falling and rising edges, before any clock could have acted. The correction sweep allows four clock periods per input change so that each advance has fully landed before the next edge is driven.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int JDC_STAGES = 5;
  localparam int JDC_STATES = 2 * JDC_STAGES;

  typedef logic [JDC_STAGES-1:0] jdc_ring_t;
  typedef logic [JDC_STATES-1:0] jdc_dec_t;

  // Twisted-ring shift with a repair term on stage 2: an isolated one
  // sitting in stage 1 is not passed on, which breaks every illegal loop.
  function automatic jdc_ring_t jdc_step(jdc_ring_t s);
    jdc_ring_t n;
    n    = {s[JDC_STAGES-2:0], ~s[JDC_STAGES-1]};
    n[2] = s[1] & (s[0] | s[2]);
    return n;
  endfunction

  // Each state is recognised from one pair of neighbouring stages.
  function automatic jdc_dec_t jdc_decode(jdc_ring_t s);
    jdc_dec_t d;
    d[0]          = ~s[0] & ~s[JDC_STAGES-1];
    d[JDC_STAGES] =  s[0] &  s[JDC_STAGES-1];
    for (int k = 1; k < JDC_STAGES; k++) begin
      d[k]              =  s[k-1] & ~s[k];
      d[k + JDC_STAGES] = ~s[k-1] &  s[k];
    end
    return d;
  endfunction

  // Legal patterns change value at most once walking from stage 0 upward.
  function automatic logic jdc_legal(jdc_ring_t s);
    int t;
    t = 0;
    for (int i = 1; i < JDC_STAGES; i++) begin
      if (s[i] != s[i-1]) t++;
    end
    return (t <= 1);
  endfunction
endpackage

// File: rtl/jdc_edge.sv
module jdc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic dn_n_i,
  output logic adv_o
);
  localparam int ARM_LIMIT = SYNC_STAGES + 1;
  localparam int ARM_W     = $clog2(ARM_LIMIT + 1);

  logic [SYNC_STAGES-1:0] up_sync, dn_sync;
  logic                   up_prev, dn_prev;
  logic [ARM_W-1:0]       arm_cnt;
  logic                   armed;
  logic                   up_lvl, dn_lvl, up_rise, dn_fall;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      up_sync <= '0;
      dn_sync <= '1;
      up_prev <= 1'b0;
      dn_prev <= 1'b1;
      arm_cnt <= '0;
    end else begin
      up_sync <= {up_sync[SYNC_STAGES-2:0], up_i};
      dn_sync <= {dn_sync[SYNC_STAGES-2:0], dn_n_i};
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end
  end

  assign armed   = (arm_cnt == ARM_W'(ARM_LIMIT));
  assign up_lvl  = up_sync[SYNC_STAGES-1];
  assign dn_lvl  = dn_sync[SYNC_STAGES-1];
  assign up_rise = up_lvl & ~up_prev;
  assign dn_fall = ~dn_lvl & dn_prev;
  assign adv_o   = armed & ((up_rise & ~dn_lvl) | (dn_fall & up_lvl));

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!up_lvl && dn_lvl) |-> !adv_o); // R4
  AST_SINGLE_ADV: assert property (@(posedge clk) disable iff (rst)
    adv_o |=> !adv_o); // R5
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      adv_i,
  input  logic      ld_en_i,
  input  jdc_ring_t ld_pat_i,
  output jdc_ring_t ring_o
);
  jdc_ring_t ring_q, ring_nxt;
  logic      ring_legal;

  assign ring_nxt   = jdc_step(ring_q);
  assign ring_legal = jdc_legal(ring_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          ring_q <= '0;
    else if (ld_en_i) ring_q <= ld_pat_i;
    else if (adv_i)   ring_q <= ring_nxt;
  end

  assign ring_o = ring_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_en_i |=> ring_q == $past(ld_pat_i)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !ld_en_i) |=> $stable(ring_q)); // R4
  AST_LEGAL_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (ring_legal && adv_i && !ld_en_i) |=> ring_legal); // R8
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
  import jdc_pkg::*;
(
  input  jdc_ring_t ring_i,
  output jdc_dec_t  dec_o,
  output logic      carry_n_o
);
  assign dec_o     = jdc_decode(ring_i);
  assign carry_n_o = ~ring_i[JDC_STAGES-1];
endmodule

// File: rtl/jdc_counter.sv
module jdc_counter
  import jdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_up_i,
  input  logic                  cnt_dn_n_i,
  input  logic                  ld_en_i,
  input  logic [JDC_STAGES-1:0] ld_pat_i,
  output logic [JDC_STATES-1:0] dec_o,
  output logic                  carry_n_o
);
  logic      adv;
  jdc_ring_t ring;
  logic      ring_legal;

  jdc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .up_i   (cnt_up_i),
    .dn_n_i (cnt_dn_n_i),
    .adv_o  (adv)
  );

  jdc_ring u_ring (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .ld_en_i  (ld_en_i),
    .ld_pat_i (ld_pat_i),
    .ring_o   (ring)
  );

  jdc_decode u_dec (
    .ring_i    (ring),
    .dec_o     (dec_o),
    .carry_n_o (carry_n_o)
  );

  assign ring_legal = jdc_legal(ring);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |-> (dec_o == JDC_STATES'(1) && carry_n_o)); // R1
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ring_legal |-> $onehot(dec_o)); // R6
  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst)
    ring_legal |-> (carry_n_o == (dec_o[JDC_STATES-1:JDC_STAGES] == '0))); // R7
endmodule

// File: tb/jdc_counter_tb.sv
`timescale 1ns/1ps
module jdc_counter_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       up, dn_n, ld_en;
  logic [4:0] ld_pat;
  logic [9:0] dec;
  logic       carry_n;

  int n_chk = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jdc_counter u_dut (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_n_i(dn_n),
    .ld_en_i(ld_en), .ld_pat_i(ld_pat), .dec_o(dec), .carry_n_o(carry_n)
  );

  function automatic logic [4:0] pat_of(int k);
    if (k <= 5) return 5'((1 << k) - 1);
    return 5'h1f & ~5'((1 << (k - 5)) - 1);
  endfunction

  task automatic chk(string tag, int k);
    logic [9:0] ed;
    logic       ec;
    ed = 10'(1 << k);
    ec = (k < 5);
    n_chk++;
    if (dec !== ed || carry_n !== ec) begin
      n_fail++;
      $display("FAIL %s: dec=%b carry_n=%b expected dec=%b carry_n=%b", tag, dec, carry_n, ed, ec);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_up(string tag);
    up = 1'b1; wait_n(4); model = (model + 1) % 10; chk(tag, model);
    up = 1'b0; wait_n(4); chk({tag, " hold"}, model);
  endtask

  task automatic step_dn(string tag);
    dn_n = 1'b0; wait_n(4); model = (model + 1) % 10; chk(tag, model);
    dn_n = 1'b1; wait_n(4); chk({tag, " hold"}, model);
  endtask

  task automatic quiet_up();
    up = 1'b1; wait_n(4); up = 1'b0; wait_n(4);
  endtask

  task automatic load(logic [4:0] p);
    ld_en = 1'b1; ld_pat = p; @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; up = 1'b0; dn_n = 1'b1; ld_en = 1'b0; ld_pat = '0;
    wait_n(3);
    chk("R1 in reset", 0);
    rst = 1'b0;
    wait_n(4);
    chk("R1 after release", 0);

    // active-high input counting, gate held low
    dn_n = 1'b0; wait_n(4); chk("R4 dn fall while up low", model);
    up = 1'b1; wait_n(2); chk("R2 not yet at edge 2", model);
    wait_n(1); model = 1; chk("R2 at edge 3", model);
    up = 1'b0; wait_n(4); chk("R4 up fall", model);
    for (int i = 0; i < 9; i++) step_up("R6 R7 R2 sweep");

    // active-low input counting, gate held high
    dn_n = 1'b1; wait_n(4); chk("R4 dn rise", model);
    up = 1'b1; wait_n(4); chk("R4 up rise while dn high", model);
    dn_n = 1'b0; wait_n(2); chk("R3 not yet at edge 2", model);
    wait_n(1); model = (model + 1) % 10; chk("R3 at edge 3", model);
    dn_n = 1'b1; wait_n(4); chk("R4 dn rise hold", model);
    for (int i = 0; i < 10; i++) step_dn("R3 R6 R7 sweep");

    // both qualifying edges in one cycle
    up = 1'b0; wait_n(4); chk("R4 up fall", model);
    up = 1'b1; dn_n = 1'b0; wait_n(4);
    model = (model + 1) % 10; chk("R5 joint edges", model);
    dn_n = 1'b1; wait_n(4); up = 1'b0; wait_n(4); chk("R5 restore", model);

    // load
    load(pat_of(7)); model = 7; chk("R9 load state 7", model);
    load(pat_of(2)); model = 2; chk("R9 load state 2", model);

    // correction sweep over all patterns
    dn_n = 1'b0; wait_n(4);
    for (int p = 0; p < 32; p++) begin
      load(5'(p));
      for (int k = 0; k < 10; k++) if (pat_of(k) == 5'(p)) chk("R9 legal preload", k);
      for (int a = 0; a < 11; a++) quiet_up();
      n_chk++;
      if ($countones(dec) != 1) begin
        n_fail++;
        $display("FAIL R8 pattern %0d: dec=%b expected one-hot", p, dec);
      end else begin
        for (int k = 0; k < 10; k++) if (dec[k]) model = k;
        chk("R8 settled carry", model);
        for (int a = 0; a < 10; a++) begin
          quiet_up(); model = (model + 1) % 10; chk("R8 sequence", model);
        end
      end
    end

    // reset overrides load and counting, asynchronously
    ld_en = 1'b1; ld_pat = pat_of(7); up = 1'b1;
    #2 rst = 1'b1;
    #1 chk("R1 async", 0);
    wait_n(3); chk("R10 reset over load and count", 0);
    ld_en = 1'b0;
    rst = 1'b0; model = 0;
    wait_n(8); chk("R11 held levels after release", 0);
    up = 1'b0; wait_n(4); chk("R11 up fall", 0);
    step_up("R2 after reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule